// File: doc/BRIEF.md
# Post-Update Store Address Unit

This unit executes the store-with-update operations of a 64-bit register machine in post-increment style. Each operation arrives already decoded. It carries an access size, a choice between an immediate and an indexed offset, the number and value of the base register, the index register value, the raw immediate field, and the source data. The unit sends the store to memory at the base value as it was before the operation. It then returns the base plus the offset so that the base register can be written back. It alters no condition or status state.

An accepted operation loads a one-entry request register. Its memory request is presented with a valid/ready handshake. The register writeback is signalled in the same cycle the memory side takes the request, so a stalled memory also holds back the writeback. Operations whose base register number is zero, and accesses that would straddle an 8-byte bus word, are refused. Each refusal produces a one-cycle error pulse and has no other effect.

Top module: `post_update_store`

## Requirements
- R1: The memory address of a request equals the base register value supplied with the operation, not the updated value.
- R2: For immediate forms of size byte, halfword and word, the writeback value is the base plus the 16-bit immediate field sign-extended to 64 bits.
- R3: For the doubleword immediate form, only the low 14 bits of the immediate field are used: they are shifted left by two, then sign-extended. Bits 15:14 have no effect.
- R4: For indexed forms (`op_indexed`=1), the writeback value is base plus index value, wrapping modulo 2^64. The immediate field has no effect.
- R5: `op_size` 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. The low bytes of the source are placed starting at lane `base[2:0]`, where lane i is `mem_data[8i+7:8i]` and `mem_be[i]` enables it. Unused lanes carry zero.
- R6: An operation with `op_base_idx`=0 is consumed and raises `err_invalid_form` for exactly the next cycle. It makes no memory request and no writeback.
- R7: An operation whose `base[2:0]` plus its byte count exceeds 8 is consumed and raises `err_misaligned` for exactly the next cycle. It makes no request and no writeback. An access that ends exactly at lane 7 is accepted.
- R8: `op_ready` is high when no request is pending or the pending one is being taken. While `mem_valid` is high and `mem_ready` is low, every request and writeback field stays unchanged.
- R9: `wb_valid` is high exactly in the cycles where `mem_valid` and `mem_ready` are both high. It carries the base register number and the updated value of the operation being stored.
- R10: After reset, `mem_valid`, `wb_valid` and both error outputs are low and `op_ready` is high. An accepted operation presents its request in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit can take an operation this cycle |
| op_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_indexed | input | 1 | 1 selects the index register as offset, 0 the immediate |
| op_base_idx | input | 5 | Base register number |
| op_base_val | input | 64 | Base register value |
| op_index_val | input | 64 | Index register value |
| op_imm | input | 16 | Raw immediate field |
| op_src | input | 64 | Source register value |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 64 | Byte address of the store |
| mem_be | output | 8 | Per-lane byte enables |
| mem_data | output | 64 | Lane-aligned store data |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_idx | output | 5 | Register number to write |
| wb_data | output | 64 | Updated base value |
| err_invalid_form | output | 1 | One-cycle pulse: base register number zero |
| err_misaligned | output | 1 | One-cycle pulse: access crosses the bus word |

## Verification
Each of the four sizes is stored at a lane offset that puts its bytes in the middle or top of the bus word. This separates correct lane steering and masking from data or enables left at lane zero. Negative, maximum-positive and wrapping offsets show whether the writeback is sign-extended, scaled for the doubleword form, or summed with the index. The memory address staying at the old base tells post-update apart from pre-update addressing. Lane offsets just inside and just past the bus word boundary, a zero base register number, and a memory stall lasting several cycles cover the refusal and hold paths. A small memory model merges two partial stores into one word, which confirms that the enables and the data agree.

// File: rtl/pus_pkg.sv
package pus_pkg;
  localparam int XLEN       = 64;
  localparam int LANES      = XLEN / 8;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DBL  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [XLEN-1:0]  addr;
    logic [LANES-1:0] be;
    logic [XLEN-1:0]  data;
    logic [XLEN-1:0]  upd;
  } store_req_t;
endpackage

// File: rtl/pus_offset_gen.sv
module pus_offset_gen
  import pus_pkg::*;
#(
  parameter int IMM_W = 16,
  parameter int DS_W  = 14
) (
  input  logic             indexed,
  input  acc_size_e        size,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  index_val,
  output logic [XLEN-1:0]  offset
);
  localparam int DSS_W = DS_W + 2;

  logic [XLEN-1:0]  d_ext;
  logic [DSS_W-1:0] ds_scaled;
  logic [XLEN-1:0]  ds_ext;

  // plain displacement, sign-extended
  assign d_ext     = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  // doubleword form: narrow field, scaled by four before extension
  assign ds_scaled = {imm[DS_W-1:0], 2'b00};
  assign ds_ext    = {{(XLEN-DSS_W){ds_scaled[DSS_W-1]}}, ds_scaled};

  always_comb begin
    if (indexed)               offset = index_val;
    else if (size == ACC_DBL)  offset = ds_ext;
    else                       offset = d_ext;
  end
endmodule

// File: rtl/pus_lane_steer.sv
module pus_lane_steer
  import pus_pkg::*;
(
  input  acc_size_e             size,
  input  logic [LANE_IDX_W-1:0] lane_off,
  input  logic [XLEN-1:0]       src,
  output logic [LANES-1:0]      be,
  output logic [XLEN-1:0]       data,
  output logic                  crosses
);
  localparam int CNT_W = LANE_IDX_W + 2;

  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] lane_end;
  logic [XLEN-1:0]  shifted;

  assign nbytes   = CNT_W'(1) << size;
  assign lane_end = CNT_W'(lane_off) + nbytes;
  assign crosses  = lane_end > CNT_W'(LANES);
  assign shifted  = src << {lane_off, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i]          = (CNT_W'(i) >= CNT_W'(lane_off)) && (CNT_W'(i) < lane_end);
    assign data[8*i +: 8] = be[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/pus_req_stage.sv
module pus_req_stage
  import pus_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 drain,
  input  store_req_t           nxt,
  input  logic [REG_IDX_W-1:0] nxt_idx,
  output logic                 valid,
  output store_req_t           cur,
  output logic [REG_IDX_W-1:0] cur_idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)      valid <= 1'b0;
    else if (load)   valid <= 1'b1;
    else if (drain)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      cur_idx <= '0;
    end else if (load) begin
      cur     <= nxt;
      cur_idx <= nxt_idx;
    end
  end
endmodule

// File: rtl/post_update_store.sv
module post_update_store
  import pus_pkg::*;
#(
  parameter int REG_IDX_W = 5,
  parameter int IMM_W     = 16,
  parameter int DS_W      = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  output logic                 op_ready,
  input  logic [1:0]           op_size,
  input  logic                 op_indexed,
  input  logic [REG_IDX_W-1:0] op_base_idx,
  input  logic [63:0]          op_base_val,
  input  logic [63:0]          op_index_val,
  input  logic [IMM_W-1:0]     op_imm,
  input  logic [63:0]          op_src,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [63:0]          mem_addr,
  output logic [7:0]           mem_be,
  output logic [63:0]          mem_data,
  output logic                 wb_valid,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [63:0]          wb_data,
  output logic                 err_invalid_form,
  output logic                 err_misaligned
);
  acc_size_e        size;
  logic [XLEN-1:0]  offset;
  logic [LANES-1:0] lane_be;
  logic [XLEN-1:0]  lane_data;
  logic             crosses;
  logic             accept;
  logic             bad_form;
  logic             load;
  store_req_t       nxt_req;
  store_req_t       cur_req;

  assign size = acc_size_e'(op_size);

  pus_offset_gen #(.IMM_W(IMM_W), .DS_W(DS_W)) u_offset (
    .indexed   (op_indexed),
    .size      (size),
    .imm       (op_imm),
    .index_val (op_index_val),
    .offset    (offset)
  );

  pus_lane_steer u_steer (
    .size     (size),
    .lane_off (op_base_val[LANE_IDX_W-1:0]),
    .src      (op_src),
    .be       (lane_be),
    .data     (lane_data),
    .crosses  (crosses)
  );

  assign op_ready = !mem_valid || mem_ready;
  assign accept   = op_valid && op_ready;
  assign bad_form = (op_base_idx == '0);
  assign load     = accept && !bad_form && !crosses;

  // memory sees the old base; the register gets the sum (wraps)
  assign nxt_req.addr = op_base_val;
  assign nxt_req.be   = lane_be;
  assign nxt_req.data = lane_data;
  assign nxt_req.upd  = op_base_val + offset;

  pus_req_stage #(.REG_IDX_W(REG_IDX_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .drain   (mem_ready),
    .nxt     (nxt_req),
    .nxt_idx (op_base_idx),
    .valid   (mem_valid),
    .cur     (cur_req),
    .cur_idx (wb_idx)
  );

  assign mem_addr = cur_req.addr;
  assign mem_be   = cur_req.be;
  assign mem_data = cur_req.data;
  assign wb_data  = cur_req.upd;
  assign wb_valid = mem_valid && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_invalid_form <= 1'b0;
      err_misaligned   <= 1'b0;
    end else begin
      err_invalid_form <= accept && bad_form;
      err_misaligned   <= accept && !bad_form && crosses;
    end
  end
endmodule

// File: rtl/pus_checker.sv
module pus_checker #(
  parameter int REG_IDX_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_ready,
  input logic                 mem_valid,
  input logic                 mem_ready,
  input logic [63:0]          mem_addr,
  input logic [7:0]           mem_be,
  input logic [63:0]          mem_data,
  input logic                 wb_valid,
  input logic [REG_IDX_W-1:0] wb_idx,
  input logic [63:0]          wb_data,
  input logic                 err_invalid_form,
  input logic                 err_misaligned
);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
      && $stable(mem_data) && $stable(wb_data) && $stable(wb_idx));

  p_ready_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> op_ready);

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |-> mem_valid && !mem_ready);

  p_wb_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> mem_valid && mem_ready);

  p_wb_idx_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx != '0);

  p_invalid_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_invalid_form |-> !mem_valid && !wb_valid);

  p_misalign_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_misaligned |-> !mem_valid && !wb_valid);

  p_err_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_invalid_form, err_misaligned}));

  p_be_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
      || $countones(mem_be) == 4 || $countones(mem_be) == 8));

  p_be_first_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_be[mem_addr[2:0]] && ((mem_be & ((8'd1 << mem_addr[2:0]) - 8'd1)) == 8'd0));
endmodule

bind post_update_store pus_checker #(.REG_IDX_W(REG_IDX_W)) u_chk (.*);

// File: tb/post_update_store_test.sv
module post_update_store_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_indexed = 1'b0;
  logic [4:0]  op_base_idx = '0;
  logic [63:0] op_base_val = '0;
  logic [63:0] op_index_val = '0;
  logic [15:0] op_imm = '0;
  logic [63:0] op_src = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [63:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_data;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic        err_invalid_form;
  logic        err_misaligned;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  post_update_store uut (.*);

  // memory model: 16 doublewords indexed by address bits 6:3
  logic [63:0] mem [16];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) mem[k] <= '0;
    end else if (mem_valid && mem_ready) begin
      for (int k = 0; k < 8; k++)
        if (mem_be[k]) mem[mem_addr[6:3]][8*k +: 8] <= mem_data[8*k +: 8];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sz, input logic ix, input logic [4:0] rn,
                      input logic [63:0] b, input logic [63:0] x,
                      input logic [15:0] im, input logic [63:0] s);
    @(negedge clk);
    op_size = sz; op_indexed = ix; op_base_idx = rn; op_base_val = b;
    op_index_val = x; op_imm = im; op_src = s; op_valid = 1'b1;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // called right after send with mem_ready high
  task automatic expect_req(input string tag, input logic [63:0] a, input logic [7:0] be,
                            input logic [63:0] d, input logic [4:0] rn, input logic [63:0] w);
    chk({tag, " R10 mem_valid"}, 64'(mem_valid), 64'd1);
    chk({tag, " R1 addr"}, mem_addr, a);
    chk({tag, " R5 be"}, 64'(mem_be), 64'(be));
    chk({tag, " R5 data"}, mem_data, d);
    chk({tag, " R9 wb_valid"}, 64'(wb_valid), 64'd1);
    chk({tag, " R9 wb_idx"}, 64'(wb_idx), 64'(rn));
    chk({tag, " wb_data"}, wb_data, w);
    @(negedge clk);
    chk({tag, " R8 drained"}, 64'(mem_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset mem_valid", 64'(mem_valid), 64'd0);
    chk("R10 reset wb_valid", 64'(wb_valid), 64'd0);
    chk("R10 reset errors", 64'({err_invalid_form, err_misaligned}), 64'd0);
    chk("R10 reset op_ready", 64'(op_ready), 64'd1);
  endtask

  task automatic t_byte_imm;
    send(2'd0, 1'b0, 5'd4, 64'h1000_0003, 64'hFFFF, 16'hFFF0, 64'h0123_4567_89AB_CDAB);
    expect_req("R2 byte neg", 64'h1000_0003, 8'h08, 64'h0000_0000_AB00_0000, 5'd4, 64'h0FFF_FFF3);
  endtask

  task automatic t_half_imm;
    send(2'd1, 1'b0, 5'd7, 64'h2000_0006, 64'h0, 16'h0100, 64'h1122_3344_5566_7788);
    expect_req("R2 half pos", 64'h2000_0006, 8'hC0, 64'h7788_0000_0000_0000, 5'd7, 64'h2000_0106);
  endtask

  task automatic t_word_imm;
    send(2'd2, 1'b0, 5'd31, 64'h3000_0004, 64'h0, 16'h7FFF, 64'hDEAD_BEEF_CAFE_F00D);
    expect_req("R2 word max", 64'h3000_0004, 8'hF0, 64'hCAFE_F00D_0000_0000, 5'd31, 64'h3000_8003);
  endtask

  task automatic t_dword_imm;
    send(2'd3, 1'b0, 5'd1, 64'h4000_0000, 64'h0, 16'h3FFF, 64'h0F0E_0D0C_0B0A_0908);
    expect_req("R3 dword minus1", 64'h4000_0000, 8'hFF, 64'h0F0E_0D0C_0B0A_0908, 5'd1, 64'h3FFF_FFFC);
    send(2'd3, 1'b0, 5'd2, 64'h0010_0000, 64'h0, 16'h2000, 64'h1);
    expect_req("R3 dword most neg", 64'h0010_0000, 8'hFF, 64'h1, 5'd2, 64'h000F_8000);
    send(2'd3, 1'b0, 5'd3, 64'h0010_0000, 64'h0, 16'hC001, 64'h2);
    expect_req("R3 dword top bits ignored", 64'h0010_0000, 8'hFF, 64'h2, 5'd3, 64'h0010_0004);
  endtask

  task automatic t_indexed_wrap;
    send(2'd2, 1'b1, 5'd9, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, 16'h8000, 64'hAAAA_AAAA_1234_5678);
    expect_req("R4 indexed wrap", 64'hFFFF_FFFF_FFFF_FFF8, 8'h0F, 64'h0000_0000_1234_5678, 5'd9, 64'h8);
  endtask

  task automatic t_invalid;
    send(2'd0, 1'b0, 5'd0, 64'h0000_0080, 64'h0, 16'h4, 64'h55);
    chk("R6 err_invalid_form", 64'(err_invalid_form), 64'd1);
    chk("R6 no request", 64'(mem_valid), 64'd0);
    chk("R6 no writeback", 64'(wb_valid), 64'd0);
    @(negedge clk);
    chk("R6 pulse one cycle", 64'(err_invalid_form), 64'd0);
  endtask

  task automatic t_misaligned;
    send(2'd1, 1'b0, 5'd5, 64'h0000_0107, 64'h0, 16'h2, 64'h1234);
    chk("R7 half at lane 7", 64'(err_misaligned), 64'd1);
    chk("R7 no request", 64'(mem_valid), 64'd0);
    chk("R7 no invalid-form", 64'(err_invalid_form), 64'd0);
    @(negedge clk);
    chk("R7 pulse one cycle", 64'(err_misaligned), 64'd0);
    send(2'd2, 1'b0, 5'd5, 64'h0000_0105, 64'h0, 16'h2, 64'h1234);
    chk("R7 word at lane 5", 64'(err_misaligned), 64'd1);
    chk("R7 word no wb", 64'(wb_valid), 64'd0);
    send(2'd0, 1'b0, 5'd5, 64'h0000_0107, 64'h0, 16'h1, 64'h99);
    chk("R7 byte at lane 7 no error", 64'(err_misaligned), 64'd0);
    expect_req("R7 byte at lane 7", 64'h107, 8'h80, 64'h9900_0000_0000_0000, 5'd5, 64'h108);
    send(2'd2, 1'b0, 5'd5, 64'h0000_0104, 64'h0, 16'h4, 64'h7654_3210);
    expect_req("R7 word ends at lane 7", 64'h104, 8'hF0, 64'h7654_3210_0000_0000, 5'd5, 64'h108);
  endtask

  task automatic t_stall;
    @(negedge clk);
    mem_ready = 1'b0;
    send(2'd0, 1'b0, 5'd3, 64'h0000_0058, 64'h0, 16'h2, 64'h77);
    chk("R8 pending", 64'(mem_valid), 64'd1);
    chk("R9 no wb while stalled", 64'(wb_valid), 64'd0);
    chk("R8 op_ready low", 64'(op_ready), 64'd0);
    op_valid = 1'b1; op_base_val = 64'h999; op_base_idx = 5'd6;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 addr held", mem_addr, 64'h58);
      chk("R8 wb_data held", wb_data, 64'h5A);
    end
    op_valid = 1'b0;
    mem_ready = 1'b1;
    #0;
    chk("R9 wb on accept", 64'(wb_valid), 64'd1);
    chk("R9 wb_idx", 64'(wb_idx), 64'd3);
    chk("R9 wb_data", wb_data, 64'h5A);
    @(negedge clk);
    chk("R8 drained after stall", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_memory;
    send(2'd0, 1'b0, 5'd10, 64'h0000_1041, 64'h0, 16'h1, 64'h5A);
    expect_req("R5 mem byte", 64'h1041, 8'h02, 64'h0000_0000_0000_5A00, 5'd10, 64'h1042);
    send(2'd1, 1'b0, 5'd11, 64'h0000_1044, 64'h0, 16'h2, 64'hFFFF_BEEF);
    expect_req("R5 mem half", 64'h1044, 8'h30, 64'h0000_BEEF_0000_0000, 5'd11, 64'h1046);
    chk("R5 memory merge", mem[8], 64'h0000_BEEF_0000_5A00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_imm();
    t_half_imm();
    t_word_imm();
    t_dword_imm();
    t_indexed_wrap();
    t_invalid();
    t_misaligned();
    t_stall();
    t_memory();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule